// File: doc/BRIEF.md
# Microcontroller Interrupt Control Sequencer

This block is the interrupt control unit of a small 8-bit microcontroller core. It watches three sources. The first is an external pin, which gives a maskable edge interrupt whose polarity software selects. The second is a timer carry or capture event, which is also maskable. The third is a decode flag saying that the fetched opcode is zero, which raises a non-maskable software trap.

All sources share a single vector. Software polls two sticky pending flags to learn which maskable source fired. At an instruction boundary the block raises a take strobe to the core. It then runs a fixed seven-cycle entry sequence: it pushes the program counter to the stack, moves the stack pointer down by two and loads the vector address.

The core reports three return instructions with decode strobes: plain return, return-and-skip, and return-with-enable. For any of them the block runs a three-cycle pop sequence that restores the program counter and moves the stack pointer up by two. Only return-with-enable also sets the global enable again. The core reaches the control and pending bits through one 8-bit register port.

Top module: `irq_sequencer`

## Requirements
- R1: The control register has this bit layout: bit0 global enable, bit1 external enable, bit2 timer enable, bit3 edge select, bit4 external pending, bit5 timer pending. Bits 7:6 read as 0, and every bit is 0 after reset. A write stores bits 5:0 and takes effect on the next cycle. `reg_rdata` always shows the current state.
- R2: The pin passes through a two-stage synchronizer. With edge select at 0, a rising transition of `ext_pin` sets external pending 3 clock edges after it occurs. With edge select at 1, a falling transition does so. The opposite transition, and a change of edge select while the pin is steady, leave the flag at 0.
- R3: A `tmr_evt` pulse sets timer pending on the next edge.
- R4: A pending flag is set by its event whatever the enables are. It stays set until a register write stores 0 there, and taking an interrupt never clears it. When an event and a write fall in the same cycle, the event wins.
- R5: `irq_req` is high exactly when the global enable is set and at least one of these holds: external enable with external pending, or timer enable with timer pending.
- R6: `irq_take` is high only in a cycle with `insn_bound` high while the sequencer is idle. In such a cycle, `op_zero` high takes the trap whatever the enables are, and otherwise `irq_req` high takes it.
- R7: A take without `op_zero` clears the global enable on the next cycle. A take with `op_zero` leaves it unchanged, even when a maskable request is also pending.
- R8: After a take, `seq_busy` stays high for exactly 7 cycles. In busy cycle 1 the stack write puts PC[15:8] at the saved SP. In cycle 2 it puts PC[7:0] at SP-1. In cycle 3 `sp_load_val` is SP-2, and in cycle 7 `pc_load_val` is 0x00FF.
- R9: While `seq_busy` is high, `irq_take` stays low, and a return strobe is dropped and starts no pop sequence.
- R10: A return strobe in an idle cycle starts three busy cycles. Cycle 1 reads address SP+1 as the low byte and cycle 2 reads SP+2 as the high byte. Cycle 3 loads the PC from those two bytes (0xFF bytes give 0xFFFF) and loads SP+2. Only the return-with-enable strobe also sets the global enable, from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_evt | input | 1 | One-cycle timer carry or capture event |
| insn_bound | input | 1 | Core is at an instruction boundary |
| op_zero | input | 1 | Fetched opcode is zero (software trap) |
| dec_ret | input | 1 | Plain return decoded |
| dec_retsk | input | 1 | Return-and-skip decoded |
| dec_reti | input | 1 | Return-with-enable decoded |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| pc_cur | input | 16 | Current program counter from the core |
| sp_cur | input | 8 | Current stack pointer from the core |
| irq_req | output | 1 | Maskable request level |
| irq_take | output | 1 | Interrupt taken this cycle |
| seq_busy | output | 1 | Entry or pop sequence in progress |
| stk_we | output | 1 | Stack byte write |
| stk_re | output | 1 | Stack byte read |
| stk_addr | output | 8 | Stack byte address |
| stk_wdata | output | 8 | Stack byte write data |
| stk_rdata | input | 8 | Stack byte read data, valid in the same cycle |
| pc_load | output | 1 | Load program counter |
| pc_load_val | output | 16 | Program counter value to load |
| sp_load | output | 1 | Load stack pointer |
| sp_load_val | output | 8 | Stack pointer value to load |

## Verification
The assertions take for granted that `op_zero` and the return strobes come only as the decode of the instruction under way. They also assume a return strobe never shares a cycle with `insn_bound`, and that software writes no register in a take cycle. The enable checks depend on that last point. The bench keeps within these limits: register writes and timer events are random only while `insn_bound` is held low, and takes and returns are driven as directed sequences with no register write in the same cycle. It raises the out-of-order strobes only during a busy sequence, where the block must drop them.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ENTRY = 2'd1,
        SEQ_POP   = 2'd2
    } seq_mode_e;

    // Bit positions of the control register as software sees it.
    localparam int CTL_GIE  = 0;
    localparam int CTL_ENX  = 1;
    localparam int CTL_ENT  = 2;
    localparam int CTL_EDGE = 3;
    localparam int CTL_PX   = 4;
    localparam int CTL_PT   = 5;

    typedef struct packed {
        logic gie;
        logic en_ext;
        logic en_tmr;
        logic edge_fall;
        logic pend_ext;
        logic pend_tmr;
    } ctl_bits_t;

endpackage

// File: rtl/irq_ext_edge.sv
module irq_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic edge_fall,
    output logic evt
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     cur;

    assign cur = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_async};
        st_d.prev = cur;
    end

    // Only a real transition of the synchronized level counts, so a change
    // of the polarity bit on a steady pin produces no event.
    always_comb begin
        if (edge_fall) evt = st_q.prev & ~cur;
        else           evt = ~st_q.prev & cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_seq_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ext_evt,
    input  logic             tmr_evt,
    input  logic             hw_take,
    input  logic             gie_set,
    output ctl_bits_t        ctl,
    output logic             req
);
    ctl_bits_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.gie       = wr_data[CTL_GIE];
            ctl_d.en_ext    = wr_data[CTL_ENX];
            ctl_d.en_tmr    = wr_data[CTL_ENT];
            ctl_d.edge_fall = wr_data[CTL_EDGE];
            ctl_d.pend_ext  = wr_data[CTL_PX];
            ctl_d.pend_tmr  = wr_data[CTL_PT];
        end
        // Hardware updates take priority over a software write.
        if (hw_take) ctl_d.gie      = 1'b0;
        if (gie_set) ctl_d.gie      = 1'b1;
        if (ext_evt) ctl_d.pend_ext = 1'b1;
        if (tmr_evt) ctl_d.pend_tmr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;
    assign req = ctl_q.gie & ((ctl_q.en_ext & ctl_q.pend_ext) |
                              (ctl_q.en_tmr & ctl_q.pend_tmr));
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
#(
    parameter int          PC_W         = 16,
    parameter int          SP_W         = 8,
    parameter int          ENTRY_CYCLES = 7,
    parameter logic [15:0] VECTOR       = 16'h00FF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                insn_bound,
    input  logic                op_zero,
    input  logic                irq_req,
    input  logic                ret_any,
    input  logic                ret_en,
    input  logic [PC_W-1:0]     pc_cur,
    input  logic [SP_W-1:0]     sp_cur,
    input  logic [PC_W/2-1:0]   stk_rdata,
    output logic                take,
    output logic                hw_take,
    output logic                gie_set,
    output logic                entry_busy,
    output logic                pop_busy,
    output logic                stk_we,
    output logic                stk_re,
    output logic [SP_W-1:0]     stk_addr,
    output logic [PC_W/2-1:0]   stk_wdata,
    output logic                pc_load,
    output logic [PC_W-1:0]     pc_load_val,
    output logic                sp_load,
    output logic [SP_W-1:0]     sp_load_val
);
    localparam int BYTE_W     = PC_W / 2;
    localparam int POP_CYCLES = 3;
    localparam int CNT_W      = $clog2(ENTRY_CYCLES + 1);

    localparam logic [CNT_W-1:0] STEP_HI   = CNT_W'(0);
    localparam logic [CNT_W-1:0] STEP_LO   = CNT_W'(1);
    localparam logic [CNT_W-1:0] STEP_SP   = CNT_W'(2);
    localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(ENTRY_CYCLES - 1);
    localparam logic [CNT_W-1:0] POP_LAST  = CNT_W'(POP_CYCLES - 1);
    localparam logic [SP_W-1:0]  SP_ONE    = SP_W'(1);
    localparam logic [SP_W-1:0]  SP_TWO    = SP_W'(2);

    typedef struct packed {
        seq_mode_e         mode;
        logic [CNT_W-1:0]  step;
        logic [PC_W-1:0]   pc_sv;
        logic [SP_W-1:0]   sp_sv;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              reti;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    idle, ret_ok;

    assign idle    = (st_q.mode == SEQ_IDLE);
    assign take    = idle & insn_bound & (op_zero | irq_req);
    assign hw_take = take & ~op_zero;
    assign ret_ok  = idle & ret_any & ~take;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            SEQ_IDLE: begin
                if (take) begin
                    st_d.mode  = SEQ_ENTRY;
                    st_d.step  = '0;
                    st_d.pc_sv = pc_cur;
                    st_d.sp_sv = sp_cur;
                end else if (ret_ok) begin
                    st_d.mode  = SEQ_POP;
                    st_d.step  = '0;
                    st_d.sp_sv = sp_cur;
                    st_d.reti  = ret_en;
                end
            end
            SEQ_ENTRY: begin
                if (st_q.step == STEP_LAST) st_d.mode = SEQ_IDLE;
                else                        st_d.step = st_q.step + CNT_W'(1);
            end
            SEQ_POP: begin
                if (st_q.step == STEP_HI) st_d.lo = stk_rdata;
                if (st_q.step == STEP_LO) st_d.hi = stk_rdata;
                if (st_q.step == POP_LAST) st_d.mode = SEQ_IDLE;
                else                       st_d.step = st_q.step + CNT_W'(1);
            end
            default: st_d.mode = SEQ_IDLE;
        endcase
    end

    always_comb begin
        entry_busy  = (st_q.mode == SEQ_ENTRY);
        pop_busy    = (st_q.mode == SEQ_POP);
        stk_we      = 1'b0;
        stk_re      = 1'b0;
        stk_addr    = st_q.sp_sv;
        stk_wdata   = st_q.pc_sv[PC_W-1:BYTE_W];
        pc_load     = 1'b0;
        pc_load_val = VECTOR[PC_W-1:0];
        sp_load     = 1'b0;
        sp_load_val = st_q.sp_sv - SP_TWO;
        gie_set     = 1'b0;
        if (entry_busy) begin
            if (st_q.step == STEP_HI) begin
                stk_we = 1'b1;
            end
            if (st_q.step == STEP_LO) begin
                stk_we    = 1'b1;
                stk_addr  = st_q.sp_sv - SP_ONE;
                stk_wdata = st_q.pc_sv[BYTE_W-1:0];
            end
            if (st_q.step == STEP_SP)   sp_load = 1'b1;
            if (st_q.step == STEP_LAST) pc_load = 1'b1;
        end
        if (pop_busy) begin
            stk_addr = (st_q.step == STEP_HI) ? st_q.sp_sv + SP_ONE
                                              : st_q.sp_sv + SP_TWO;
            stk_re   = (st_q.step != POP_LAST);
            if (st_q.step == POP_LAST) begin
                pc_load     = 1'b1;
                pc_load_val = {st_q.hi, st_q.lo};
                sp_load     = 1'b1;
                sp_load_val = st_q.sp_sv + SP_TWO;
                gie_set     = st_q.reti;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import irq_seq_pkg::*;
#(
    parameter int          PC_W         = 16,
    parameter int          SP_W         = 8,
    parameter int          REG_W        = 8,
    parameter int          SYNC_STAGES  = 2,
    parameter int          ENTRY_CYCLES = 7,
    parameter logic [15:0] VECTOR       = 16'h00FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_pin,
    input  logic               tmr_evt,
    input  logic               insn_bound,
    input  logic               op_zero,
    input  logic               dec_ret,
    input  logic               dec_retsk,
    input  logic               dec_reti,
    input  logic               reg_we,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [PC_W-1:0]    pc_cur,
    input  logic [SP_W-1:0]    sp_cur,
    output logic               irq_req,
    output logic               irq_take,
    output logic               seq_busy,
    output logic               stk_we,
    output logic               stk_re,
    output logic [SP_W-1:0]    stk_addr,
    output logic [PC_W/2-1:0]  stk_wdata,
    input  logic [PC_W/2-1:0]  stk_rdata,
    output logic               pc_load,
    output logic [PC_W-1:0]    pc_load_val,
    output logic               sp_load,
    output logic [SP_W-1:0]    sp_load_val
);
    ctl_bits_t ctl;
    logic      ext_evt, hw_take, gie_set, entry_busy, pop_busy;

    irq_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (ext_pin),
        .edge_fall (ctl.edge_fall),
        .evt       (ext_evt)
    );

    irq_ctl_regs #(.REG_W(REG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_data (reg_wdata),
        .ext_evt (ext_evt),
        .tmr_evt (tmr_evt),
        .hw_take (hw_take),
        .gie_set (gie_set),
        .ctl     (ctl),
        .req     (irq_req)
    );

    irq_seq_fsm #(
        .PC_W         (PC_W),
        .SP_W         (SP_W),
        .ENTRY_CYCLES (ENTRY_CYCLES),
        .VECTOR       (VECTOR)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_bound  (insn_bound),
        .op_zero     (op_zero),
        .irq_req     (irq_req),
        .ret_any     (dec_ret | dec_retsk | dec_reti),
        .ret_en      (dec_reti),
        .pc_cur      (pc_cur),
        .sp_cur      (sp_cur),
        .stk_rdata   (stk_rdata),
        .take        (irq_take),
        .hw_take     (hw_take),
        .gie_set     (gie_set),
        .entry_busy  (entry_busy),
        .pop_busy    (pop_busy),
        .stk_we      (stk_we),
        .stk_re      (stk_re),
        .stk_addr    (stk_addr),
        .stk_wdata   (stk_wdata),
        .pc_load     (pc_load),
        .pc_load_val (pc_load_val),
        .sp_load     (sp_load),
        .sp_load_val (sp_load_val)
    );

    assign seq_busy = entry_busy | pop_busy;

    always_comb begin
        reg_rdata           = '0;
        reg_rdata[CTL_GIE]  = ctl.gie;
        reg_rdata[CTL_ENX]  = ctl.en_ext;
        reg_rdata[CTL_ENT]  = ctl.en_tmr;
        reg_rdata[CTL_EDGE] = ctl.edge_fall;
        reg_rdata[CTL_PX]   = ctl.pend_ext;
        reg_rdata[CTL_PT]   = ctl.pend_tmr;
    end
endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
    parameter int          ENTRY_CYCLES = 7,
    parameter logic [15:0] VECTOR       = 16'h00FF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_bound,
    input logic        op_zero,
    input logic        reg_we,
    input logic [7:0]  reg_rdata,
    input logic        irq_req,
    input logic        irq_take,
    input logic        seq_busy,
    input logic        entry_busy,
    input logic        stk_we,
    input logic [7:0]  stk_addr,
    input logic        pc_load,
    input logic [15:0] pc_load_val
);
    logic [7:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          run_cnt <= '0;
        else if (entry_busy) run_cnt <= run_cnt + 8'd1;
        else                 run_cnt <= '0;
    end

    assert_take_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> insn_bound);

    assert_req_needs_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> reg_rdata[0]);

    assert_pend_ext_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[4] && !reg_we) |=> reg_rdata[4]);

    assert_pend_tmr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[5] && !reg_we) |=> reg_rdata[5]);

    assert_hw_clears_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !op_zero && !reg_we) |=> !reg_rdata[0]);

    assert_sw_keeps_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && op_zero && !reg_we) |=> reg_rdata[0] == $past(reg_rdata[0]));

    assert_entry_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(entry_busy) |-> run_cnt == 8'(ENTRY_CYCLES));

    assert_push_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we && !$past(stk_we)) |=> (stk_we && stk_addr == $past(stk_addr) - 8'd1));

    assert_entry_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && entry_busy) |-> pc_load_val == VECTOR);

    assert_no_take_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> !irq_take);
endmodule

bind irq_sequencer irq_sequencer_chk #(
    .ENTRY_CYCLES (ENTRY_CYCLES),
    .VECTOR       (VECTOR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_bound  (insn_bound),
    .op_zero     (op_zero),
    .reg_we      (reg_we),
    .reg_rdata   (reg_rdata),
    .irq_req     (irq_req),
    .irq_take    (irq_take),
    .seq_busy    (seq_busy),
    .entry_busy  (entry_busy),
    .stk_we      (stk_we),
    .stk_addr    (stk_addr),
    .pc_load     (pc_load),
    .pc_load_val (pc_load_val)
);

// File: tb/irq_sequencer_tb.sv
`timescale 1ns/1ps
module irq_sequencer_tb;
    localparam int RAM_TOP = 8'h70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pin = 1'b0, tmr_evt = 1'b0, insn_bound = 1'b0, op_zero = 1'b0;
    logic        dec_ret = 1'b0, dec_retsk = 1'b0, dec_reti = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0, reg_rdata;
    logic [15:0] pc_cur = '0;
    logic [7:0]  sp_cur = '0;
    logic        irq_req, irq_take, seq_busy, stk_we, stk_re, pc_load, sp_load;
    logic [7:0]  stk_addr, stk_wdata, stk_rdata, sp_load_val;
    logic [15:0] pc_load_val;
    logic [7:0]  ram [0:RAM_TOP-1];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_evt(tmr_evt),
        .insn_bound(insn_bound), .op_zero(op_zero),
        .dec_ret(dec_ret), .dec_retsk(dec_retsk), .dec_reti(dec_reti),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pc_cur(pc_cur), .sp_cur(sp_cur), .irq_req(irq_req), .irq_take(irq_take),
        .seq_busy(seq_busy), .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
        .stk_wdata(stk_wdata), .stk_rdata(stk_rdata), .pc_load(pc_load),
        .pc_load_val(pc_load_val), .sp_load(sp_load), .sp_load_val(sp_load_val)
    );

    // Stack RAM: addresses at or above RAM_TOP are undefined and read 0xFF.
    assign stk_rdata = (stk_addr < 8'(RAM_TOP)) ? ram[stk_addr] : 8'hFF;
    always @(posedge clk) if (stk_we && stk_addr < 8'(RAM_TOP)) ram[stk_addr] <= stk_wdata;

    function automatic logic [7:0] model_next(input logic [7:0] cur, input logic we,
                                              input logic [7:0] wd, input logic tev);
        logic [7:0] n = cur;
        if (we)  n = {2'b00, wd[5:0]};
        if (tev) n[5] = 1'b1;
        return n;
    endfunction

    function automatic logic model_req(input logic [7:0] c);
        return c[0] & ((c[1] & c[4]) | (c[2] & c[5]));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        reg_we = 1'b1; reg_wdata = v;
        tick();
        reg_we = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] model;
        logic [7:0] exp;
        void'($urandom(32'd1234));
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 reset reg", reg_rdata, 8'h00);
        check("R9 reset busy", seq_busy, 0);

        // Random register traffic and timer events (R1 R3 R4 R5)
        model = 8'h00;
        for (int i = 0; i < 400; i++) begin
            logic we, tev;
            logic [7:0] wd;
            we  = ($urandom % 6) == 0;
            tev = ($urandom % 4) == 0;
            wd  = 8'($urandom);
            reg_we = we; reg_wdata = wd; tmr_evt = tev;
            exp = model_next(model, we, wd, tev);
            tick();
            reg_we = 1'b0; tmr_evt = 1'b0;
            check("R4 random reg", reg_rdata, exp);
            check("R5 random req", irq_req, model_req(exp));
            model = exp;
        end

        // R2 edge detection
        wr(8'h00);
        ext_pin = 1'b1;
        tick(); tick();
        check("R2 rise not yet", reg_rdata[4], 0);
        tick();
        check("R2 rise sets pend", reg_rdata[4], 1);
        wr(8'h00);
        ext_pin = 1'b0;
        repeat (4) tick();
        check("R2 fall ignored in rise mode", reg_rdata[4], 0);
        wr(8'h08);
        repeat (3) tick();
        check("R2 edge select change alone", reg_rdata[4], 0);
        ext_pin = 1'b1;
        repeat (4) tick();
        check("R2 rise ignored in fall mode", reg_rdata[4], 0);
        ext_pin = 1'b0;
        repeat (3) tick();
        check("R2 fall sets pend", reg_rdata[4], 1);
        // R4 pend set with enables off, request once enabled
        check("R5 no req while disabled", irq_req, 0);
        wr(8'h1B);
        check("R5 req after enable", irq_req, 1);
        wr(8'h00);

        // Hardware entry via timer
        wr(8'h05);
        tmr_evt = 1'b1; tick(); tmr_evt = 1'b0;
        check("R3 timer pend", reg_rdata[5], 1);
        check("R5 timer req", irq_req, 1);
        tick();
        check("R6 no take without boundary", irq_take, 0);
        pc_cur = 16'h1234; sp_cur = 8'h6F;
        insn_bound = 1'b1; #1;
        check("R6 take at boundary", irq_take, 1);
        tick(); insn_bound = 1'b0;
        check("R7 hw take clears gie", reg_rdata[0], 0);
        check("R8 busy", seq_busy, 1);
        check("R8 push hi we", stk_we, 1);
        check("R8 push hi addr", stk_addr, 8'h6F);
        check("R8 push hi data", stk_wdata, 8'h12);
        tick();
        check("R8 push lo addr", {stk_we, stk_addr}, {1'b1, 8'h6E});
        check("R8 push lo data", stk_wdata, 8'h34);
        tick();
        check("R8 sp step", {sp_load, sp_load_val}, {1'b1, 8'h6D});
        tick();
        insn_bound = 1'b1; op_zero = 1'b1; dec_ret = 1'b1; #1;
        check("R9 no take while busy", irq_take, 0);
        tick(); insn_bound = 1'b0; op_zero = 1'b0; dec_ret = 1'b0;
        tick(); tick();
        check("R8 vector", {pc_load, pc_load_val}, {1'b1, 16'h00FF});
        check("R8 still busy last", seq_busy, 1);
        tick();
        check("R8 seven cycles", seq_busy, 0);
        tick();
        check("R9 dropped return", {seq_busy, stk_re}, 2'b00);
        check("R4 ack keeps pend", reg_rdata[5], 1);

        // Return with enable
        sp_cur = 8'h6D;
        wr(8'h04);
        dec_reti = 1'b1; tick(); dec_reti = 1'b0;
        check("R10 pop lo", {stk_re, stk_addr}, {1'b1, 8'h6E});
        tick();
        check("R10 pop hi", {stk_re, stk_addr}, {1'b1, 8'h6F});
        tick();
        check("R10 pop pc", {pc_load, pc_load_val}, {1'b1, 16'h1234});
        check("R10 pop sp", {sp_load, sp_load_val}, {1'b1, 8'h6F});
        tick();
        check("R10 reti sets gie", reg_rdata[0], 1);

        // Plain return keeps gie low
        wr(8'h00);
        dec_ret = 1'b1; tick(); dec_ret = 1'b0;
        tick(); tick();
        check("R10 ret pc", pc_load_val, 16'h1234);
        tick();
        check("R10 ret leaves gie", reg_rdata[0], 0);

        // Unbalanced return into undefined RAM
        sp_cur = 8'h6F;
        dec_retsk = 1'b1; tick(); dec_retsk = 1'b0;
        tick(); tick();
        check("R10 undefined pop pc", {pc_load, pc_load_val}, {1'b1, 16'hFFFF});
        check("R10 undefined pop sp", sp_load_val, 8'h71);
        tick();

        // Software trap: gie low still taken; gie high with pending kept
        sp_cur = 8'h50; pc_cur = 16'h0ABC;
        insn_bound = 1'b1; op_zero = 1'b1; #1;
        check("R6 trap with gie low", irq_take, 1);
        tick(); insn_bound = 1'b0; op_zero = 1'b0;
        repeat (7) tick();
        wr(8'h25);
        insn_bound = 1'b1; op_zero = 1'b1; #1;
        check("R6 trap with pending", irq_take, 1);
        tick(); insn_bound = 1'b0; op_zero = 1'b0;
        check("R7 trap keeps gie", reg_rdata[0], 1);
        repeat (7) tick();
        check("R8 trap entry done", seq_busy, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule